// File: doc/BRIEF.md
# Memory Controller Operating-State Sequencer

This block holds the global operating state of a DRAM protocol controller. Software changes that state by writing a command code. It reads the result back through a 7-bit status word. The low three bits give the current state. Bits 6:4 say what put the controller into low power.

The sequencer never jumps straight from one stable state to another. It first passes through a request state. That state ends when the neighbouring logic pulses an acknowledge, or when a parameterised number of cycles has elapsed, whichever comes first. A command that is not legal from the current state is dropped. Any command that arrives while a request state is still pending is also dropped.

When hardware low-power entry is enabled, an idle request from the surrounding fabric can also take the controller into low power. In that case the fabric, not software, decides when low power ends.

Top module: `opstate_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `stat_o` reads 0: state init, trigger 0.
- R2: The state field uses 0 init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request and 7 low-power-exit-request. Command code 1 (config) written in init or access moves to config-request and then to config. Config is entered only from config-request.
- R3: Command code 2 (go) written in config moves to access-request and then to access.
- R4: With no acknowledge, a request state lasts exactly `REQ_CYCLES` cycles. An acknowledge seen in a request state ends it at the next clock edge.
- R5: Command code 3 (sleep) in access moves to low-power-entry-request and then to low-power, with trigger field 2 (software). Low-power can be left only through low-power-exit-request.
- R6: Command code 4 (wakeup) in a software-triggered low-power moves to low-power-exit-request. Low power always exits to access, never to config. The trigger field returns to 0 when access is reached.
- R7: In access, with `hw_lp_enable` high, a high `hw_lp_request` starts low-power entry with trigger field 1 (hardware). With `hw_lp_enable` low, the request has no effect. The trigger field is non-zero only in states 5, 6 and 7.
- R8: In a hardware-triggered low-power, a wakeup command is ignored. Exit begins when `hw_lp_request` goes low.
- R9: A command not legal in the current state, any command written during a request state, and an acknowledge outside a request state all leave `stat_o` unchanged.
- R10: Command code 0 (init) written in config returns the state to init directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 3 | Command code (0 init, 1 config, 2 go, 3 sleep, 4 wakeup) |
| hw_lp_enable | input | 1 | Configuration bit 0: permit hardware-triggered low power |
| hw_lp_request | input | 1 | Idle request from the fabric for hardware low power |
| req_ack | input | 1 | Acknowledge that ends the current request state |
| stat_o | output | 7 | Status: [2:0] state, [3] zero, [6:4] low-power trigger |

## Verification
The bench writes commands that are illegal from init, from config and from low power. A sequencer that decoded commands without looking at its state would leave the stable state on such a write. It also writes a command in the middle of a request state, which a design that re-arms its request timer would accept. Request states are timed both without an acknowledge and with one. An off-by-one counter shows up as a status change one cycle early or late. The low-power exits are checked against the trigger: a wakeup command during hardware low power must not wake the controller, the trigger must clear on return, and an exit that lands in config instead of access is caught at once.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT     = 3'd0,
    ST_CONFIG   = 3'd1,
    ST_CFG_REQ  = 3'd2,
    ST_ACCESS   = 3'd3,
    ST_ACC_REQ  = 3'd4,
    ST_LOWPWR   = 3'd5,
    ST_LP_ENTRY = 3'd6,
    ST_LP_EXIT  = 3'd7
  } op_state_t;

  localparam logic [2:0] CMD_INIT   = 3'd0;
  localparam logic [2:0] CMD_CONFIG = 3'd1;
  localparam logic [2:0] CMD_GO     = 3'd2;
  localparam logic [2:0] CMD_SLEEP  = 3'd3;
  localparam logic [2:0] CMD_WAKEUP = 3'd4;

  localparam logic [2:0] TRIG_NONE = 3'd0;
  localparam logic [2:0] TRIG_HW   = 3'd1;
  localparam logic [2:0] TRIG_SW   = 3'd2;

endpackage

// File: rtl/opstate_decode.sv
module opstate_decode
  import opstate_pkg::*;
(
  input  op_state_t   state,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_code,
  input  logic        hw_lp_enable,
  input  logic        hw_lp_request,
  input  logic [2:0]  trig,
  output logic        take,
  output op_state_t   next_state,
  output logic [2:0]  next_trig
);

  always_comb begin
    take       = 1'b0;
    next_state = state;
    next_trig  = trig;
    unique case (state)
      ST_INIT: begin
        if (cmd_wr && cmd_code == CMD_CONFIG) begin
          take       = 1'b1;
          next_state = ST_CFG_REQ;
        end
      end
      ST_CONFIG: begin
        if (cmd_wr && cmd_code == CMD_GO) begin
          take       = 1'b1;
          next_state = ST_ACC_REQ;
        end else if (cmd_wr && cmd_code == CMD_INIT) begin
          take       = 1'b1;
          next_state = ST_INIT;
        end
      end
      ST_ACCESS: begin
        if (cmd_wr && cmd_code == CMD_CONFIG) begin
          take       = 1'b1;
          next_state = ST_CFG_REQ;
        end else if (cmd_wr && cmd_code == CMD_SLEEP) begin
          take       = 1'b1;
          next_state = ST_LP_ENTRY;
          next_trig  = TRIG_SW;
        end else if (hw_lp_enable && hw_lp_request) begin
          take       = 1'b1;
          next_state = ST_LP_ENTRY;
          next_trig  = TRIG_HW;
        end
      end
      ST_LOWPWR: begin
        if (trig == TRIG_HW) begin
          if (!hw_lp_request) begin
            take       = 1'b1;
            next_state = ST_LP_EXIT;
          end
        end else if (cmd_wr && cmd_code == CMD_WAKEUP) begin
          take       = 1'b1;
          next_state = ST_LP_EXIT;
        end
      end
      default: begin
        take = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/opstate_req_timer.sv
module opstate_req_timer #(
  parameter int REQ_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_req,
  input  logic ack,
  output logic done
);

  localparam int CW = (REQ_CYCLES < 2) ? 1 : $clog2(REQ_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(REQ_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = in_req && (ack || cnt_q == LAST);
  assign cnt_en = in_req || (cnt_q != '0);

  always_comb begin
    if (!in_req || done) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4
  req_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R4
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_req |=> cnt_q == '0);

endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
#(
  parameter int REQ_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [2:0] cmd_code,
  input  logic       hw_lp_enable,
  input  logic       hw_lp_request,
  input  logic       req_ack,
  output logic [6:0] stat_o
);

  op_state_t  state_q, state_d, dec_next;
  logic [2:0] trig_q, trig_d, dec_trig;
  logic       dec_take, in_req, req_done;

  assign in_req = (state_q == ST_CFG_REQ) || (state_q == ST_ACC_REQ) ||
                  (state_q == ST_LP_ENTRY) || (state_q == ST_LP_EXIT);

  opstate_decode u_decode (
    .state         (state_q),
    .cmd_wr        (cmd_wr),
    .cmd_code      (cmd_code),
    .hw_lp_enable  (hw_lp_enable),
    .hw_lp_request (hw_lp_request),
    .trig          (trig_q),
    .take          (dec_take),
    .next_state    (dec_next),
    .next_trig     (dec_trig)
  );

  opstate_req_timer #(.REQ_CYCLES(REQ_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_req (in_req),
    .ack    (req_ack),
    .done   (req_done)
  );

  always_comb begin
    state_d = state_q;
    trig_d  = trig_q;
    if (req_done) begin
      unique case (state_q)
        ST_CFG_REQ:  state_d = ST_CONFIG;
        ST_ACC_REQ:  state_d = ST_ACCESS;
        ST_LP_ENTRY: state_d = ST_LOWPWR;
        ST_LP_EXIT: begin
          state_d = ST_ACCESS;
          trig_d  = TRIG_NONE;
        end
        default:     state_d = state_q;
      endcase
    end else if (dec_take) begin
      state_d = dec_next;
      trig_d  = dec_trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      trig_q  <= TRIG_NONE;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
    end
  end

  assign stat_o = {trig_q, 1'b0, state_q};

  // R2
  cfg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONFIG && $past(state_q) != ST_CONFIG) |->
      $past(state_q) == ST_CFG_REQ);

  // R5
  lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LOWPWR |=> (state_q == ST_LOWPWR || state_q == ST_LP_EXIT));

  // R6
  lp_exit_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_LP_EXIT |=> (state_q == ST_LP_EXIT || state_q == ST_ACCESS));

  // R7
  trig_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q != TRIG_NONE |->
      (state_q == ST_LOWPWR || state_q == ST_LP_ENTRY || state_q == ST_LP_EXIT));

  // R8
  hw_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOWPWR && trig_q == TRIG_HW && hw_lp_request) |=>
      state_q == ST_LOWPWR);

  // R9
  req_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ACC_REQ |=> (state_q == ST_ACC_REQ || state_q == ST_ACCESS));

endmodule

// File: tb/opstate_ctrl_test.sv
module opstate_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic       cmd_wr;
  logic [2:0] cmd_code;
  logic       hw_lp_enable;
  logic       hw_lp_request;
  logic       req_ack;
  logic [6:0] stat_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [6:0] exp_q[$];
  string      tag_q[$];

  opstate_ctrl #(.REQ_CYCLES(4)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .cmd_code      (cmd_code),
    .hw_lp_enable  (hw_lp_enable),
    .hw_lp_request (hw_lp_request),
    .req_ack       (req_ack),
    .stat_o        (stat_o)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // driver: one input vector per cycle, expected status after the next edge
  task automatic step(input logic wr, input logic [2:0] c, input logic ack,
                      input logic en, input logic hreq,
                      input logic [2:0] est, input logic [2:0] etr,
                      input string tag);
    @(negedge clk);
    cmd_wr        = wr;
    cmd_code      = c;
    req_ack       = ack;
    hw_lp_enable  = en;
    hw_lp_request = hreq;
    exp_q.push_back({etr, 1'b0, est});
    tag_q.push_back(tag);
  endtask

  // monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (stat_o !== e) begin
          fails++;
          $display("FAIL %s: stat_o=%h expected %h", t, stat_o, e);
        end
      end
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_code = 3'd0; req_ack = 1'b0;
    hw_lp_enable = 1'b0; hw_lp_request = 1'b0;
    #10;
    checks++;
    if (stat_o !== 7'h00) begin
      fails++;
      $display("FAIL R1: stat_o=%h expected %h", stat_o, 7'h00);
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step(0, 3'd0, 0, 0, 0, 3'd0, 3'd0, "R1 idle after reset");
    step(1, 3'd2, 0, 0, 0, 3'd0, 3'd0, "R9 go in init");
    step(1, 3'd3, 0, 0, 0, 3'd0, 3'd0, "R9 sleep in init");
    step(1, 3'd1, 0, 0, 0, 3'd2, 3'd0, "R2 config from init");
    step(0, 3'd0, 0, 0, 0, 3'd2, 3'd0, "R4 req cycle 2");
    step(1, 3'd2, 0, 0, 0, 3'd2, 3'd0, "R9 cmd during request");
    step(0, 3'd0, 0, 0, 0, 3'd2, 3'd0, "R4 req cycle 4");
    step(0, 3'd0, 0, 0, 0, 3'd1, 3'd0, "R4 timeout enters config");
    step(1, 3'd3, 0, 0, 0, 3'd1, 3'd0, "R9 sleep in config");
    step(1, 3'd2, 0, 0, 0, 3'd4, 3'd0, "R3 go from config");
    step(0, 3'd0, 1, 0, 0, 3'd3, 3'd0, "R4 ack ends request");
    step(0, 3'd0, 1, 0, 1, 3'd3, 3'd0, "R7 R9 hw req disabled, stray ack");
    step(1, 3'd3, 0, 0, 1, 3'd6, 3'd2, "R5 sleep from access");
    step(0, 3'd0, 1, 0, 0, 3'd5, 3'd2, "R5 enter low power");
    step(1, 3'd1, 0, 0, 0, 3'd5, 3'd2, "R9 config in low power");
    step(1, 3'd4, 0, 0, 0, 3'd7, 3'd2, "R6 wakeup");
    step(0, 3'd0, 1, 0, 0, 3'd3, 3'd0, "R6 exit to access");
    step(0, 3'd0, 0, 1, 1, 3'd6, 3'd1, "R7 hw entry");
    step(0, 3'd0, 1, 1, 1, 3'd5, 3'd1, "R7 hw low power");
    step(1, 3'd4, 0, 1, 1, 3'd5, 3'd1, "R8 wakeup ignored");
    step(0, 3'd0, 0, 1, 0, 3'd7, 3'd1, "R8 hw exit");
    step(0, 3'd0, 1, 1, 0, 3'd3, 3'd0, "R6 R8 back to access");
    step(1, 3'd1, 0, 1, 0, 3'd2, 3'd0, "R2 config from access");
    step(0, 3'd0, 1, 0, 0, 3'd1, 3'd0, "R2 config reached");
    step(1, 3'd0, 0, 0, 0, 3'd0, 3'd0, "R10 init from config");
    @(negedge clk);
    cmd_wr = 1'b0; req_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule